// File: doc/BRIEF.md
# Multiplexed Parallel Flash Bus Sequencer

This block turns single-byte read and write requests from a host into complete cycles on an external parallel flash bus. Address and data share one 8-bit bus. The two upper address bytes are captured by external latches, each clocked by its own latch strobe. The three lowest address bits go out on dedicated pins for the whole cycle. A larger address map can be switched on. In that map, an extra latch phase with both strobes high loads a third 3-bit latch that carries the top address bits. Together this gives 19 address bits in the small map and 22 bits in the large map.

A 32-bit timing word sets the length of each cycle. Every timed phase has a short count field and a separate extension bit, and the extension bit is the most significant bit of that count. The block accepts one request at a time and captures the address, data, direction, map size and timing word when it accepts a request. It stays busy through a bus turn-off period at the end of the cycle. It signals completion with a one-clock acknowledge, and for reads the returned byte is valid at that moment.

Top module: `pflash_seq`

## Requirements
- R1: After reset, and whenever the block is not busy, chip enable, output enable and write enable are high (inactive), both latch strobes are low, the shared bus is not driven, and busy and acknowledge are low.
- R2: When the small map is selected (wide_mode_i = 0 at acceptance), the block drives address bits [18:11] on the bus during exactly one clock with strobe bit 0 alone high. In the next clock it drives bits [10:3] with strobe bit 1 alone high. Bits [2:0] stay on the low-address pins. No clock has both strobes high, and bits [21:19] have no effect.
- R3: When the large map is selected, one extra clock comes before the two byte phases. In that clock both strobes are high and the bus carries address bits [21:19] in its low three bits, with the upper bus bits at zero.
- R4: Timing word layout: turn-off count in [2:0] with extension bit 22; read access count in [6:3] with extension bit 23; setup count in [13:11] with extension bit 25; write-low count in [16:14] with extension bit 26; write-high count in [19:17] with extension bit 27. Each phase lasts {extension, field} clocks, and a value of 0 lasts 1 clock. Bits [10:7], 24, [21:20] and [31:28] have no effect.
- R5: A write drives the write data on the bus with write enable high for the setup count. Write enable is then low for exactly the write-low count, with the write data on the bus. After that, write enable is high for the write-high count.
- R6: A read holds output enable low for exactly the read access count while the block leaves the bus undriven. The returned byte is the bus value in the last clock of that window.
- R7: After the data phase, chip enable goes high and the bus is released for the turn-off count while busy stays high. A write therefore keeps busy high for L + setup + write-low + write-high + turn-off clocks, and a read for L + access + turn-off clocks, where L is 2 in the small map and 3 in the large map.
- R8: Acknowledge is a single-clock pulse in the first turn-off clock. For reads, the returned byte is valid while acknowledge is high.
- R9: A request raised while busy is ignored. Changes to the address, data, direction, map selection or timing word during a cycle do not alter that cycle.
- R10: Chip enable is low for every busy clock outside the turn-off period. Output enable and write enable are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request; accepted when the block is idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| timing_i | input | 32 | Packed timing word |
| wide_mode_i | input | 1 | 1 selects the 22-bit map with the third latch |
| busy_o | output | 1 | A cycle is in progress, including turn-off |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Returned read byte |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |
| fl_ale_o | output | 2 | Address latch strobes |
| fl_ad_o | output | 8 | Outgoing value on the shared bus |
| fl_ad_oe_o | output | 1 | Drive enable of the shared bus |
| fl_ad_i | input | 8 | Incoming value on the shared bus |
| fl_alow_o | output | 3 | Direct low address pins |

## Verification
The bench builds the block with its default parameters: an 8-bit shared bus, three direct address pins, a 3-bit third latch and 5-bit phase counters. With these values it can reach both map sizes and every extension bit, so it can check phase counts above the field maximum, such as 17 and 13 clocks. It can also check all-zero counts, which become single-clock phases, and timing words whose unused bits are all set. The bench models the external latches and a memory that returns a value derived from the latched address. This model lets it rebuild every latched address byte and compare it with the returned byte.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int TW_W  = 32;
    localparam int CNT_W = 5;

    // field positions inside the timing word (decoded by pfb_tdecode)
    localparam int TO_LSB  = 0;   localparam int TO_X  = 22;
    localparam int AF_LSB  = 3;   localparam int AF_X  = 23;
    localparam int SU_LSB  = 11;  localparam int SU_X  = 25;
    localparam int WL_LSB  = 14;  localparam int WL_X  = 26;
    localparam int WH_LSB  = 17;  localparam int WH_X  = 27;

    typedef struct packed {
        logic [CNT_W-1:0] turn_off;
        logic [CNT_W-1:0] acc_first;
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] wr_low;
        logic [CNT_W-1:0] wr_high;
    } timing_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LATX,
        PH_LAT0,
        PH_LAT1,
        PH_SETUP,
        PH_WRLOW,
        PH_WRHIGH,
        PH_ACCESS,
        PH_TURNOFF
    } phase_t;

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic       we_n;
        logic [1:0] ale;
        logic       ad_oe;
    } strobes_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/pfb_tdecode.sv
module pfb_tdecode
    import pfb_pkg::*;
(
    input  logic [TW_W-1:0] word_i,
    output timing_t         tim_o
);
    logic [CNT_W-1:0] raw_to, raw_af, raw_su, raw_wl, raw_wh;
    logic             unused_bits;

    always_comb begin
        raw_to = {1'b0, word_i[TO_X], word_i[TO_LSB +: 3]};
        raw_af = {word_i[AF_X], word_i[AF_LSB +: 4]};
        raw_su = {1'b0, word_i[SU_X], word_i[SU_LSB +: 3]};
        raw_wl = {1'b0, word_i[WL_X], word_i[WL_LSB +: 3]};
        raw_wh = {1'b0, word_i[WH_X], word_i[WH_LSB +: 3]};
    end

    // burst field, its extension and the reserved bits carry no meaning here
    assign unused_bits = ^{word_i[31:28], word_i[24], word_i[21:20], word_i[10:7]};

    assign tim_o.turn_off  = at_least_one(raw_to);
    assign tim_o.acc_first = at_least_one(raw_af);
    assign tim_o.setup     = at_least_one(raw_su);
    assign tim_o.wr_low    = at_least_one(raw_wl);
    assign tim_o.wr_high   = at_least_one(raw_wh);

endmodule

// File: rtl/pfb_timer.sv
module pfb_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (len_i == '0) ? '0 : len_i - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last_o = (cnt_q == '0);

    // R4: a finished count never wraps around
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pfb_pindrv.sv
module pfb_pindrv
    import pfb_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int LOW_W  = 3,
    parameter int XLAT_W = 3,
    localparam int ADDR_W = LOW_W + 2 * BUS_W + XLAT_W
) (
    input  phase_t            phase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output strobes_t          str_o,
    output logic [BUS_W-1:0]  ad_o,
    output logic [LOW_W-1:0]  alow_o
);
    localparam int B1_LSB = LOW_W;
    localparam int B0_LSB = LOW_W + BUS_W;
    localparam int BX_LSB = LOW_W + 2 * BUS_W;

    logic [BUS_W-1:0] byte0, byte1, bytex;

    assign byte0  = addr_i[B0_LSB +: BUS_W];
    assign byte1  = addr_i[B1_LSB +: BUS_W];
    assign alow_o = addr_i[LOW_W-1:0];

    generate
        if (XLAT_W >= BUS_W) begin : g_xfull
            assign bytex = addr_i[BX_LSB +: BUS_W];
        end else begin : g_xpad
            assign bytex = {{(BUS_W - XLAT_W){1'b0}}, addr_i[BX_LSB +: XLAT_W]};
        end
    endgenerate

    always_comb begin
        str_o = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, ale: 2'b00, ad_oe: 1'b0};
        ad_o  = '0;
        case (phase_i)
            PH_LATX: begin
                str_o.ce_n = 1'b0; str_o.ale = 2'b11; str_o.ad_oe = 1'b1; ad_o = bytex;
            end
            PH_LAT0: begin
                str_o.ce_n = 1'b0; str_o.ale = 2'b01; str_o.ad_oe = 1'b1; ad_o = byte0;
            end
            PH_LAT1: begin
                str_o.ce_n = 1'b0; str_o.ale = 2'b10; str_o.ad_oe = 1'b1; ad_o = byte1;
            end
            PH_SETUP, PH_WRHIGH: begin
                str_o.ce_n = 1'b0; str_o.ad_oe = 1'b1; ad_o = wdata_i;
            end
            PH_WRLOW: begin
                str_o.ce_n = 1'b0; str_o.we_n = 1'b0; str_o.ad_oe = 1'b1; ad_o = wdata_i;
            end
            PH_ACCESS: begin
                str_o.ce_n = 1'b0; str_o.oe_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
    import pfb_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int LOW_W  = 3,
    parameter int XLAT_W = 3,
    localparam int ADDR_W = LOW_W + 2 * BUS_W + XLAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    input  logic [TW_W-1:0]   timing_i,
    input  logic              wide_mode_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              fl_ce_n_o,
    output logic              fl_oe_n_o,
    output logic              fl_we_n_o,
    output logic [1:0]        fl_ale_o,
    output logic [BUS_W-1:0]  fl_ad_o,
    output logic              fl_ad_oe_o,
    input  logic [BUS_W-1:0]  fl_ad_i,
    output logic [LOW_W-1:0]  fl_alow_o
);
    localparam int SMALL_W = LOW_W + 2 * BUS_W;

    phase_t            st_q, st_d;
    timing_t           tim_new, tim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q, rdata_q;
    logic              wr_q, ack_q;
    logic              accept, finish, t_load, t_last;
    logic [CNT_W-1:0]  t_len;
    strobes_t          str;

    pfb_tdecode u_tdec (
        .word_i (timing_i),
        .tim_o  (tim_new)
    );

    pfb_timer #(.CW(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (t_load),
        .len_i  (t_len),
        .last_o (t_last)
    );

    pfb_pindrv #(.BUS_W(BUS_W), .LOW_W(LOW_W), .XLAT_W(XLAT_W)) u_pins (
        .phase_i (st_q),
        .addr_i  (addr_q),
        .wdata_i (wdata_q),
        .str_o   (str),
        .ad_o    (fl_ad_o),
        .alow_o  (fl_alow_o)
    );

    assign accept = (st_q == PH_IDLE) && req_i;

    always_comb begin
        st_d   = st_q;
        t_load = 1'b0;
        t_len  = CNT_W'(1);
        finish = 1'b0;
        case (st_q)
            PH_IDLE:  if (req_i) st_d = wide_mode_i ? PH_LATX : PH_LAT0;
            PH_LATX:  st_d = PH_LAT0;
            PH_LAT0:  st_d = PH_LAT1;
            PH_LAT1: begin
                t_load = 1'b1;
                if (wr_q) begin
                    st_d  = PH_SETUP;
                    t_len = tim_q.setup;
                end else begin
                    st_d  = PH_ACCESS;
                    t_len = tim_q.acc_first;
                end
            end
            PH_SETUP: if (t_last) begin
                st_d = PH_WRLOW;  t_load = 1'b1; t_len = tim_q.wr_low;
            end
            PH_WRLOW: if (t_last) begin
                st_d = PH_WRHIGH; t_load = 1'b1; t_len = tim_q.wr_high;
            end
            PH_WRHIGH, PH_ACCESS: if (t_last) begin
                st_d   = PH_TURNOFF;
                t_load = 1'b1;
                t_len  = tim_q.turn_off;
                finish = 1'b1;
            end
            PH_TURNOFF: if (t_last) st_d = PH_IDLE;
            default:  st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PH_IDLE;
            tim_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            st_q  <= st_d;
            ack_q <= finish;
            if (accept) begin
                tim_q   <= tim_new;
                wdata_q <= req_wdata_i;
                wr_q    <= req_wr_i;
                // the top latch only exists in the large map
                addr_q  <= wide_mode_i ? req_addr_i
                                       : {{XLAT_W{1'b0}}, req_addr_i[SMALL_W-1:0]};
            end
            if (finish && !wr_q) rdata_q <= fl_ad_i;
        end
    end

    assign busy_o     = (st_q != PH_IDLE);
    assign ack_o      = ack_q;
    assign rdata_o    = rdata_q;
    assign fl_ce_n_o  = str.ce_n;
    assign fl_oe_n_o  = str.oe_n;
    assign fl_we_n_o  = str.we_n;
    assign fl_ale_o   = str.ale;
    assign fl_ad_oe_o = str.ad_oe;

    // R1: idle bus is quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (fl_ce_n_o && fl_oe_n_o && fl_we_n_o && fl_ale_o == 2'b00 && !fl_ad_oe_o));

    // R6: no drive while the flash drives the bus
    p_bus_free_read_r6: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n_o |-> !fl_ad_oe_o);

    // R10: the two data strobes are exclusive
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!fl_oe_n_o && !fl_we_n_o));

    // R10: write enable only with chip enable
    p_we_in_ce_r10: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n_o |-> !fl_ce_n_o);

    // R8: acknowledge is a single pulse inside the busy window
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    p_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> busy_o);

    // R9: a cycle in progress keeps its address
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(addr_q));

endmodule

// File: tb/test_pflash_seq.sv
module test_pflash_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, req_wr_i = 1'b0, wide_mode_i = 1'b0;
    logic [21:0] req_addr_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic [31:0] timing_i = '0;
    logic        busy_o, ack_o, fl_ce_n_o, fl_oe_n_o, fl_we_n_o, fl_ad_oe_o;
    logic [7:0]  rdata_o, fl_ad_o, fl_ad_i;
    logic [1:0]  fl_ale_o;
    logic [2:0]  fl_alow_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pflash_seq i_pflash_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .req_wr_i(req_wr_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .timing_i(timing_i),
        .wide_mode_i(wide_mode_i), .busy_o(busy_o), .ack_o(ack_o), .rdata_o(rdata_o),
        .fl_ce_n_o(fl_ce_n_o), .fl_oe_n_o(fl_oe_n_o), .fl_we_n_o(fl_we_n_o),
        .fl_ale_o(fl_ale_o), .fl_ad_o(fl_ad_o), .fl_ad_oe_o(fl_ad_oe_o),
        .fl_ad_i(fl_ad_i), .fl_alow_o(fl_alow_o)
    );

    // external latches and memory model
    logic [2:0] lat_x;
    logic [7:0] lat0, lat1;
    logic [2:0] low_seen;

    function automatic logic [7:0] mdl(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5;
    endfunction

    assign fl_ad_i = fl_oe_n_o ? 8'h00 : mdl({lat_x, lat0, lat1, fl_alow_o});

    // monitor, samples at the falling edge
    bit mon_en = 0;
    int n_busy, n_we, n_oe, n_ack, n_alex, n_ale0, n_ale1, n_ce_off, n_ce_on, n_clash;
    logic [7:0] we_data, ack_data;

    always @(negedge clk) begin
        if (mon_en) begin
            if (busy_o) begin
                n_busy++;
                if (fl_ce_n_o) n_ce_off++; else n_ce_on++;
                if (fl_ce_n_o && fl_ad_oe_o) n_clash++;
            end
            if (!fl_we_n_o) begin
                n_we++; we_data = fl_ad_o;
                if (!fl_ad_oe_o) n_clash++;
            end
            if (!fl_oe_n_o) begin
                n_oe++;
                if (fl_ad_oe_o) n_clash++;
            end
            if (!fl_oe_n_o && !fl_we_n_o) n_clash++;
            if (ack_o) begin n_ack++; ack_data = rdata_o; end
            case (fl_ale_o)
                2'b11: begin n_alex++; lat_x = fl_ad_o[2:0];
                             if (fl_ad_o[7:3] != 0) n_clash++; end
                2'b01: begin n_ale0++; lat0 = fl_ad_o; low_seen = fl_alow_o; end
                2'b10: begin n_ale1++; lat1 = fl_ad_o; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tw(input int to, input int af, input int su,
                                       input int wl, input int wh);
        logic [31:0] w = '0;
        w[2:0]   = to[2:0]; w[22] = to[3];
        w[6:3]   = af[3:0]; w[23] = af[4];
        w[13:11] = su[2:0]; w[25] = su[3];
        w[16:14] = wl[2:0]; w[26] = wl[3];
        w[19:17] = wh[2:0]; w[27] = wh[3];
        return w;
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // issue one request; optionally disturb inputs while busy
    task automatic run_txn(input bit wr, input logic [21:0] a, input logic [7:0] d,
                           input bit wide, input logic [31:0] w, input bit disturb);
        int guard;
        @(posedge clk); #1;
        n_busy = 0; n_we = 0; n_oe = 0; n_ack = 0; n_alex = 0; n_ale0 = 0; n_ale1 = 0;
        n_ce_off = 0; n_ce_on = 0; n_clash = 0; we_data = 0; ack_data = 0;
        lat_x = 0; lat0 = 0; lat1 = 0; low_seen = 0;
        mon_en = 1;
        req_wr_i = wr; req_addr_i = a; req_wdata_i = d; wide_mode_i = wide; timing_i = w;
        req_i = 1;
        @(posedge clk); #1;
        req_i = 0;
        if (disturb) begin
            @(posedge clk); #1;
            req_i = 1; req_wr_i = ~wr; req_addr_i = ~a; req_wdata_i = ~d;
            wide_mode_i = ~wide; timing_i = tw(1, 1, 1, 1, 1);
            repeat (3) @(posedge clk);
            #1 req_i = 0;
        end
        guard = 0;
        while (busy_o && guard < 2000) begin
            @(posedge clk); #1; guard++;
        end
        repeat (3) @(posedge clk);
        #1 mon_en = 0;
    endtask

    task automatic verify(input string tg, input bit wr, input logic [21:0] a,
                          input logic [7:0] d, input bit wide,
                          input int to, input int af, input int su, input int wl, input int wh);
        logic [21:0] ea = wide ? a : {3'b000, a[18:0]};
        int lat_n = wide ? 3 : 2;
        int body  = wr ? (eff(su) + eff(wl) + eff(wh)) : eff(af);
        chk({tg, " R2"}, "strobe0 pulses", n_ale0, 1);
        chk({tg, " R2"}, "strobe1 pulses", n_ale1, 1);
        chk({tg, " R2"}, "latched byte0", lat0, ea[18:11]);
        chk({tg, " R2"}, "latched byte1", lat1, ea[10:3]);
        chk({tg, " R2"}, "low pins", low_seen, ea[2:0]);
        chk({tg, " R3"}, "dual-strobe phases", n_alex, wide ? 1 : 0);
        if (wide) chk({tg, " R3"}, "third latch", lat_x, ea[21:19]);
        chk({tg, " R7"}, "busy clocks", n_busy, lat_n + body + eff(to));
        chk({tg, " R7"}, "turn-off clocks", n_ce_off, eff(to));
        chk({tg, " R10"}, "ce low clocks", n_ce_on, lat_n + body);
        chk({tg, " R10"}, "bus conflicts", n_clash, 0);
        chk({tg, " R8"}, "ack pulses", n_ack, 1);
        if (wr) begin
            chk({tg, " R5"}, "write-low clocks", n_we, eff(wl));
            chk({tg, " R5"}, "write data", we_data, d);
            chk({tg, " R5"}, "oe clocks", n_oe, 0);
        end else begin
            chk({tg, " R6"}, "oe clocks", n_oe, eff(af));
            chk({tg, " R6"}, "read data", ack_data, mdl(ea));
            chk({tg, " R6"}, "we clocks", n_we, 0);
        end
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "ce_n", fl_ce_n_o, 1);
        chk("R1", "oe_n", fl_oe_n_o, 1);
        chk("R1", "we_n", fl_we_n_o, 1);
        chk("R1", "ale", fl_ale_o, 0);
        chk("R1", "ad_oe", fl_ad_oe_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "ack", ack_o, 0);
    endtask

    task automatic t_write_small;
        run_txn(1, 22'h05A5C3, 8'h3C, 0, tw(2, 4, 2, 3, 2), 0);
        verify("wr_small", 1, 22'h05A5C3, 8'h3C, 0, 2, 4, 2, 3, 2);
        chk("R1", "idle ce_n after write", fl_ce_n_o, 1);
    endtask

    task automatic t_read_small;
        // top address bits set but the small map must ignore them
        run_txn(0, 22'h3C1234, 8'h00, 0, tw(3, 5, 1, 1, 1), 0);
        verify("rd_small", 0, 22'h3C1234, 8'h00, 0, 3, 5, 1, 1, 1);
    endtask

    task automatic t_wide;
        run_txn(0, 22'h3ABCDE, 8'h00, 1, tw(1, 2, 2, 2, 2), 0);
        verify("rd_wide R3", 0, 22'h3ABCDE, 8'h00, 1, 1, 2, 2, 2, 2);
        run_txn(1, 22'h2F0F17, 8'hE1, 1, tw(2, 2, 3, 4, 5), 0);
        verify("wr_wide R3", 1, 22'h2F0F17, 8'hE1, 1, 2, 2, 3, 4, 5);
    endtask

    task automatic t_ext_bits;
        // extension bits in use, burst field and reserved bits all ones (R4)
        logic [31:0] w = tw(13, 17, 12, 11, 9) | 32'hF130_0780;
        run_txn(1, 22'h012345, 8'h5A, 0, w, 0);
        verify("ext_wr R4", 1, 22'h012345, 8'h5A, 0, 13, 17, 12, 11, 9);
        run_txn(0, 22'h054321, 8'h00, 0, w, 0);
        verify("ext_rd R4", 0, 22'h054321, 8'h00, 0, 13, 17, 12, 11, 9);
    endtask

    task automatic t_zero_counts;
        run_txn(1, 22'h000008, 8'h81, 0, 32'h0, 0);
        verify("zero_wr R4", 1, 22'h000008, 8'h81, 0, 0, 0, 0, 0, 0);
        run_txn(0, 22'h07FFFF, 8'h00, 1, 32'h0, 0);
        verify("zero_rd R4", 0, 22'h07FFFF, 8'h00, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_busy_ignore;
        run_txn(1, 22'h011111, 8'h77, 0, tw(4, 3, 3, 8, 6), 1);
        verify("ignore R9", 1, 22'h011111, 8'h77, 0, 4, 3, 3, 8, 6);
        chk("R9", "busy after intruding request", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_write_small();
        t_read_small();
        t_wide();
        t_ext_bits();
        t_zero_counts();
        t_busy_ignore();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule